// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Detector

This block watches 32 general-purpose input pins and turns pin activity into one interrupt request for a processor. Software configures each pin through a 16-bit register interface. The configuration covers level or edge sensing, the polarity that counts as active, whether a detected event is latched or passed straight through, and which edge directions count. Each 16-bit register covers one half of the pins: pins 0 to 15 live in the even ("low") register of a pair and pins 16 to 31 in the register two bytes above it ("high").

Every pin keeps a status bit. The block ANDs the status bits with per-pin enable bits, ORs the result into a single interrupt output, and encodes the lowest-numbered enabled pending pin, so the handler can dispatch without scanning. Latched status is cleared by writing ones to the status register.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset, every register reads 0, `irq_o` is low and `irq_idx_o` is 0.
- R2: Register pairs sit at byte offsets status 0x08/0x0A, enable 0x0C/0x0E, type 0x10/0x12, active level 0x14/0x16, hold 0x18/0x1A, falling enable 0x20/0x22 and rising enable 0x24/0x26. Pin p < 16 is bit p of the low register and pin p >= 16 is bit p-16 of the high register. Configuration registers read back the last value written, and any other offset reads 0.
- R3: With type bit 0 (level), a pin's status bit is 1 exactly while the pin is at its active level (active-level bit 1 = high, 0 = low). The status change appears after the third rising clock edge following the pin change.
- R4: A write to a type register clears the hold bit of every pin whose new type bit is 0 and leaves the others unchanged.
- R5: With type bit 1 (edge), a 0-to-1 pin transition is an event only if the pin's rising-enable bit is 1. A 1-to-0 transition is an event only if its falling-enable bit is 1. With both bits set, both directions count.
- R6: For an edge pin with hold bit 1, an event sets the status bit. The bit then stays set until a status write with a 1 in that bit position, and a 0 in that position leaves it set.
- R7: For an edge pin with hold bit 0, each event sets the status bit for exactly one clock cycle.
- R8: When an event and a clearing write reach the same pin in the same cycle, the status bit is 1 afterwards.
- R9: `irq_o` is the OR of status AND enable over all 32 pins. Clearing an enable bit masks the pin without altering its status bit.
- R10: `irq_idx_o` gives the lowest pin number whose status and enable bits are both 1, so low-half pins take precedence over high-half pins. It is 0 while `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pins_i | input | 32 | Asynchronous general-purpose pin inputs |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset, for both read and write |
| wdata_i | input | 16 | Register write data |
| rdata_o | output | 16 | Register read data for `addr_i` (combinational) |
| irq_o | output | 1 | Cascaded interrupt request |
| irq_idx_o | output | 5 | Lowest enabled pending pin number |

## Verification
On every cycle, assertions check the per-pin status rules:
- an event always leaves status set;
- a latched bit survives unless it is cleared, and a clear with no event drops it;
- a pass-through bit falls when there is no event;
- the encoded index points at an enabled pending pin with nothing lower;
- zero enables keep the output low;
- a type write leaves no hold bit set on a level pin.

Only the bench's scenarios can show the following:
- the register map and the bit placement of the high half;
- the three-edge synchronizer latency;
- the polarity selection;
- which edge directions count under each control setting;
- that a written zero leaves latched status untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // byte offsets of the low register of each pair; high register is +2
  localparam int STAT_A = 'h08;
  localparam int EN_A   = 'h0C;
  localparam int TYPE_A = 'h10;
  localparam int ACT_A  = 'h14;
  localparam int HOLD_A = 'h18;
  localparam int FALL_A = 'h20;
  localparam int RISE_A = 'h24;
  localparam int HALF_STRIDE = 2;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic edge_mode_i,
  input  logic act_high_i,
  input  logic hold_i,
  input  logic rise_en_i,
  input  logic fall_en_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q, status_q;
  logic rise, fall, active, evt, hold_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign rise     = pin_i & ~prev_q;
  assign fall     = ~pin_i & prev_q;
  assign active   = act_high_i ? pin_i : ~pin_i;
  assign evt      = edge_mode_i ? ((rise_en_i & rise) | (fall_en_i & fall)) : active;
  assign hold_eff = hold_i & edge_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       status_q <= 1'b0;
    else if (hold_eff) status_q <= evt | (status_q & ~clr_i); // event beats clear
    else               status_q <= evt;
  end

  assign status_o = status_q;

  // R8
  evt_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> status_q);
  // R6
  hold_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_eff && status_q && !clr_i) |=> status_q);
  // R6
  w1c_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_eff && clr_i && !evt) |=> !status_q);
  // R7
  thru_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_eff && !evt) |=> !status_q);
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
  parameter int unsigned W = 32,
  localparam int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign valid_o = |req_i;
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NUM_PINS = 2 * REG_W,
  localparam int unsigned IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pins_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic                irq_o,
  output logic [IDX_W-1:0]    irq_idx_o
);
  logic [NUM_PINS-1:0] en_q, type_q, act_q, hold_q, fall_q, rise_q;
  logic [NUM_PINS-1:0] status, clr, pend, pin_s;

  function automatic logic at(input logic [ADDR_W-1:0] a, input int base, input int h);
    return a == ADDR_W'(base + HALF_STRIDE * h);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      type_q <= '0;
      act_q  <= '0;
      hold_q <= '0;
      fall_q <= '0;
      rise_q <= '0;
    end else if (we_i) begin
      for (int h = 0; h < 2; h++) begin
        if (at(addr_i, EN_A, h))   en_q[h*REG_W +: REG_W]   <= wdata_i;
        if (at(addr_i, ACT_A, h))  act_q[h*REG_W +: REG_W]  <= wdata_i;
        if (at(addr_i, FALL_A, h)) fall_q[h*REG_W +: REG_W] <= wdata_i;
        if (at(addr_i, RISE_A, h)) rise_q[h*REG_W +: REG_W] <= wdata_i;
        if (at(addr_i, HOLD_A, h)) hold_q[h*REG_W +: REG_W] <= wdata_i;
        if (at(addr_i, TYPE_A, h)) begin
          type_q[h*REG_W +: REG_W] <= wdata_i;
          hold_q[h*REG_W +: REG_W] <= hold_q[h*REG_W +: REG_W] & wdata_i; // level drops hold
        end
      end
    end
  end

  always_comb begin
    clr = '0;
    for (int h = 0; h < 2; h++) begin
      if (we_i && at(addr_i, STAT_A, h)) clr[h*REG_W +: REG_W] = wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int h = 0; h < 2; h++) begin
      if (at(addr_i, STAT_A, h)) rdata_o = status[h*REG_W +: REG_W];
      if (at(addr_i, EN_A, h))   rdata_o = en_q[h*REG_W +: REG_W];
      if (at(addr_i, TYPE_A, h)) rdata_o = type_q[h*REG_W +: REG_W];
      if (at(addr_i, ACT_A, h))  rdata_o = act_q[h*REG_W +: REG_W];
      if (at(addr_i, HOLD_A, h)) rdata_o = hold_q[h*REG_W +: REG_W];
      if (at(addr_i, FALL_A, h)) rdata_o = fall_q[h*REG_W +: REG_W];
      if (at(addr_i, RISE_A, h)) rdata_o = rise_q[h*REG_W +: REG_W];
    end
  end

  gpio_irq_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .q_o    (pin_s)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_cell
    gpio_irq_cell u_cell (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .pin_i       (pin_s[p]),
      .edge_mode_i (type_q[p]),
      .act_high_i  (act_q[p]),
      .hold_i      (hold_q[p]),
      .rise_en_i   (rise_q[p]),
      .fall_en_i   (fall_q[p]),
      .clr_i       (clr[p]),
      .status_o    (status[p])
    );
  end

  assign pend = status & en_q;

  gpio_irq_prio #(.W(NUM_PINS)) u_prio (
    .req_i   (pend),
    .valid_o (irq_o),
    .idx_o   (irq_idx_o)
  );

  // R4
  type_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && at(addr_i, TYPE_A, 0)) |=> ((hold_q[REG_W-1:0] & ~$past(wdata_i)) == '0));
  // R9
  mask_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q == '0) |-> !irq_o);
  // R10
  idx_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status[irq_idx_o] && en_q[irq_idx_o]));
  // R10
  idx_lowest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ((pend & ((NUM_PINS'(1) << irq_idx_o) - NUM_PINS'(1))) == '0));
  // R10
  idx_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> (irq_idx_o == '0));
endmodule

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pins = '1;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [4:0]  idx;
  int          n_chk = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pins_i    (pins),
    .we_i      (we),
    .addr_i    (addr),
    .wdata_i   (wdata),
    .rdata_o   (rdata),
    .irq_o     (irq),
    .irq_idx_o (idx)
  );

  // {r4_flag, write addr, write data, read addr, expected}
  localparam logic [48:0] VEC [14] = '{
    {1'b0, 8'h10, 16'hA5A5, 8'h10, 16'hA5A5},
    {1'b0, 8'h18, 16'hFFFF, 8'h18, 16'hFFFF},
    {1'b1, 8'h10, 16'h00FF, 8'h18, 16'h00FF},
    {1'b0, 8'h12, 16'h1234, 8'h12, 16'h1234},
    {1'b0, 8'h1A, 16'hFFFF, 8'h1A, 16'hFFFF},
    {1'b1, 8'h12, 16'h0000, 8'h1A, 16'h0000},
    {1'b0, 8'h14, 16'h5A5A, 8'h14, 16'h5A5A},
    {1'b0, 8'h16, 16'hC3C3, 8'h16, 16'hC3C3},
    {1'b0, 8'h0C, 16'h0F0F, 8'h0C, 16'h0F0F},
    {1'b0, 8'h0E, 16'hF0F0, 8'h0E, 16'hF0F0},
    {1'b0, 8'h20, 16'h1111, 8'h20, 16'h1111},
    {1'b0, 8'h22, 16'h2222, 8'h22, 16'h2222},
    {1'b0, 8'h24, 16'h3333, 8'h26, 16'h0000},
    {1'b0, 8'h26, 16'h4444, 8'h30, 16'h0000}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [7:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, {16'h0, v}, {16'h0, exp});
  endtask

  task automatic do_reset;
    rst_ni = 1'b0;
    step(1);
    rst_ni = 1'b1;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    step(2);
    do_reset();
    // R1 reset state
    chk_reg("R1 status lo", 8'h08, 16'h0);
    chk_reg("R1 status hi", 8'h0A, 16'h0);
    chk_reg("R1 enable lo", 8'h0C, 16'h0);
    chk_reg("R1 enable hi", 8'h0E, 16'h0);
    chk_reg("R1 type lo", 8'h10, 16'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 idx", {27'h0, idx}, 32'h0);
    step(4);

    // R2 map and readback, R4 type write drops hold
    for (int i = 0; i < 14; i++) begin
      logic [15:0] v;
      wr(VEC[i][47:40], VEC[i][39:24]);
      rd(VEC[i][23:16], v);
      chk(VEC[i][48] ? "R4 hold after type write" : "R2 readback", {16'h0, v}, {16'h0, VEC[i][15:0]});
    end

    do_reset();
    chk_reg("R1 config cleared", 8'h10, 16'h0);
    step(4);

    // R3 level, active high on pin 3
    pins[3] = 1'b0;
    wr(8'h14, 16'h0008);
    step(3);
    chk_reg("R3 inactive", 8'h08, 16'h0);
    pins[3] = 1'b1;
    step(2);
    chk_reg("R3 latency", 8'h08, 16'h0);
    step(1);
    chk_reg("R3 active high", 8'h08, 16'h0008);
    chk("R9 masked", {31'h0, irq}, 32'h0);
    wr(8'h0C, 16'h0008);
    chk("R9 irq", {31'h0, irq}, 32'h1);
    chk("R10 idx 3", {27'h0, idx}, 32'd3);
    pins[3] = 1'b0;
    step(3);
    chk_reg("R3 follows", 8'h08, 16'h0);
    chk("R9 irq off", {31'h0, irq}, 32'h0);

    // R3 active low on pin 20, R2 high half mapping
    pins[20] = 1'b0;
    step(3);
    chk_reg("R3 active low hi", 8'h0A, 16'h0010);
    wr(8'h0E, 16'h0010);
    chk("R10 idx 20", {27'h0, idx}, 32'd20);
    pins[3] = 1'b1;
    step(3);
    chk("R10 low half first", {27'h0, idx}, 32'd3);
    wr(8'h0C, 16'h0);
    chk("R10 idx back 20", {27'h0, idx}, 32'd20);
    wr(8'h0E, 16'h0);
    chk("R9 masked irq", {31'h0, irq}, 32'h0);
    chk("R10 idx idle", {27'h0, idx}, 32'h0);
    chk_reg("R9 status kept", 8'h0A, 16'h0010);
    pins[3] = 1'b0;
    pins[20] = 1'b1;
    step(3);

    // R5 and R6 edge with hold on pin 5
    wr(8'h10, 16'h0020);
    wr(8'h18, 16'h0020);
    wr(8'h24, 16'h0020);
    pins[5] = 1'b0;
    step(4);
    chk_reg("R5 fall ignored", 8'h08, 16'h0);
    pins[5] = 1'b1;
    step(3);
    chk_reg("R5 rise", 8'h08, 16'h0020);
    step(6);
    chk_reg("R6 held", 8'h08, 16'h0020);
    wr(8'h08, 16'h0000);
    chk_reg("R6 zero write", 8'h08, 16'h0020);
    wr(8'h08, 16'h0020);
    chk_reg("R6 cleared", 8'h08, 16'h0);

    wr(8'h24, 16'h0000);
    wr(8'h20, 16'h0020);
    pins[5] = 1'b0;
    step(3);
    chk_reg("R5 fall", 8'h08, 16'h0020);
    wr(8'h08, 16'h0020);
    wr(8'h24, 16'h0020);
    pins[5] = 1'b1;
    step(3);
    chk_reg("R5 both rise", 8'h08, 16'h0020);
    wr(8'h08, 16'h0020);
    pins[5] = 1'b0;
    step(3);
    chk_reg("R5 both fall", 8'h08, 16'h0020);

    // R8 event and clear in the same cycle
    pins[5] = 1'b1;
    step(2);
    wr(8'h08, 16'h0020);
    chk_reg("R8 event wins", 8'h08, 16'h0020);
    wr(8'h08, 16'h0020);

    // R7 pass-through edge
    wr(8'h18, 16'h0000);
    pins[5] = 1'b0;
    step(3);
    chk_reg("R7 pulse", 8'h08, 16'h0020);
    step(1);
    chk_reg("R7 one cycle", 8'h08, 16'h0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule